// File: doc/BRIEF.md
# One-hot quad-rail link codec

This block is the sending and receiving end of a delay-insensitive link. The sender carries a binary symbol of `SYM_BITS` bits (two by default) over `2**SYM_BITS` rails, with exactly one rail raised per symbol. The receiver does not use a strobe. It finds each symbol from the rails themselves: any raised rail means a codeword is present. It splits the rails into a true/false rail pair per bit and rebuilds the binary value from the true rails.

Traffic follows a four-phase, return-to-zero handshake. The sender raises one rail and holds it until the acknowledge rises. It then drops every rail to the all-low spacer and waits for the acknowledge to fall before it takes the next word. The receiver raises the acknowledge one clock after any rail goes high. It drops the acknowledge one clock after all rails are low again. It emits the decoded word for a single clock and flags any codeword that has more than one raised rail.

Both halves share one clock. They are kept as separate ports so that the rails and the acknowledge can be wired or tapped between them.

Top module: `qr_link`

## Requirements
- R1: While reset is asserted, `tx_rail`, `rx_ack`, `out_valid` and `rx_err` are all 0.
- R2: An accepted word of value v raises only rail v of `tx_rail`. With two bits: 0→0001, 1→0010, 2→0100, 3→1000 (bit 0 is the rightmost).
- R3: `in_ready` is high only while the sender is idle, its rails are all low and `tx_ack` is low. A word is taken on a clock edge where `in_valid` and `in_ready` are both high, and the codeword appears on `tx_rail` after that edge.
- R4: The sender holds its codeword until it sees `tx_ack` high. On the following edge all rails go low.
- R5: Two codewords on `tx_rail` are always separated by at least one all-low cycle. After the spacer, `in_ready` rises only once `tx_ack` has been seen low.
- R6: `rx_ack` is the OR of the receiver rails delayed by one clock. It rises the cycle after any rail is high and falls the cycle after all rails are low.
- R7: The decoded word has bit k high when any raised rail has bit k set in its index. For two bits: bit0 = rail1|rail3 and bit1 = rail2|rail3. Words arrive in the order they were sent.
- R8: `out_valid` is high for exactly one clock, in the cycle in which `rx_ack` rises, and only for a single-hot codeword.
- R9: `rx_err` is high in the cycle after the receiver rails held more than one raised rail, and low otherwise.
- R10: A multi-hot codeword produces no `out_valid` pulse, but it still raises `rx_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_word | input | SYM_BITS | Word to send |
| in_valid | input | 1 | `in_word` is offered |
| in_ready | output | 1 | Sender can take a word this cycle |
| tx_rail | output | 2**SYM_BITS | Sender rails, one-hot or all-low |
| tx_ack | input | 1 | Acknowledge seen by the sender |
| rx_rail | input | 2**SYM_BITS | Rails seen by the receiver |
| rx_ack | output | 1 | Receiver acknowledge |
| out_word | output | SYM_BITS | Decoded word |
| out_valid | output | 1 | One-clock strobe for `out_word` |
| rx_err | output | 1 | Multi-hot codeword seen on the previous cycle |

## Verification
The bench builds the block with `SYM_BITS = 2`. At that size all four codewords can be sent, and the rails are few enough to force two-hot and three-hot patterns by hand. The sender and receiver are looped back through a multiplexer, so the handshake can run freely or illegal codewords can be injected on the receiver side. A behavioural model predicts the rails, acknowledge, ready, strobe and error flag on every cycle. It also checks that words come out in the order they went in.

// File: rtl/qr_link_pkg.sv
package qr_link_pkg;
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_DATA  = 2'd1,
        TX_DRAIN = 2'd2
    } tx_phase_e;
endpackage

// File: rtl/qr_tx.sv
module qr_tx
    import qr_link_pkg::*;
#(
    parameter int SYM_BITS = 2,
    localparam int RAILS = 1 << SYM_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SYM_BITS-1:0] word_i,
    input  logic                valid_i,
    output logic                ready_o,
    output logic [RAILS-1:0]    rail_o,
    input  logic                ack_i
);
    typedef struct packed {
        tx_phase_e        phase;
        logic [RAILS-1:0] rail;
    } tx_state_t;

    tx_state_t st_d, st_q;

    assign ready_o = (st_q.phase == TX_IDLE) && !ack_i;
    assign rail_o  = st_q.rail;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            TX_IDLE: begin
                if (valid_i && ready_o) begin
                    st_d.rail         = '0;
                    st_d.rail[word_i] = 1'b1;
                    st_d.phase        = TX_DATA;
                end
            end
            TX_DATA: begin
                if (ack_i) begin
                    st_d.rail  = '0;
                    st_d.phase = TX_DRAIN;
                end
            end
            TX_DRAIN: begin
                if (!ack_i) st_d.phase = TX_IDLE;
            end
            default: begin
                st_d.rail  = '0;
                st_d.phase = TX_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= TX_IDLE;
            st_q.rail  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: rails are never multi-hot
    a_r2_onehot_rail: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rail_o));
    // R3: an accepted word shows up on the rails
    a_r3_accept_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ready_o) |=> (rail_o != '0));
    // R4: codeword is held until acknowledged
    a_r4_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ((rail_o != '0) && !ack_i) |=> (rail_o == $past(rail_o)));
    // R5: a codeword only ever changes to the spacer
    a_r5_spacer_between: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_o != '0) |=> ((rail_o == $past(rail_o)) || (rail_o == '0)));
endmodule

// File: rtl/qr_dec.sv
module qr_dec #(
    parameter int SYM_BITS = 2,
    localparam int RAILS = 1 << SYM_BITS
) (
    input  logic [RAILS-1:0]    rail_i,
    output logic                any_o,
    output logic [SYM_BITS-1:0] bit_true_o,
    output logic [SYM_BITS-1:0] bit_false_o,
    output logic                clash_o
);
    assign any_o = |rail_i;

    for (genvar k = 0; k < SYM_BITS; k++) begin : g_bit
        always_comb begin
            bit_true_o[k]  = 1'b0;
            bit_false_o[k] = 1'b0;
            for (int r = 0; r < RAILS; r++) begin
                if (((r >> k) & 1) == 1) bit_true_o[k]  = bit_true_o[k]  | rail_i[r];
                else                     bit_false_o[k] = bit_false_o[k] | rail_i[r];
            end
        end
    end

    // two distinct raised rails differ in at least one index bit
    assign clash_o = |(bit_true_o & bit_false_o);
endmodule

// File: rtl/qr_rx.sv
module qr_rx #(
    parameter int SYM_BITS = 2,
    localparam int RAILS = 1 << SYM_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [RAILS-1:0]    rail_i,
    output logic                ack_o,
    output logic [SYM_BITS-1:0] word_o,
    output logic                valid_o,
    output logic                err_o
);
    typedef struct packed {
        logic                ack;
        logic                valid;
        logic                err;
        logic [SYM_BITS-1:0] word;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic                any_w, clash_w;
    logic [SYM_BITS-1:0] bt_w, bf_w;

    qr_dec #(.SYM_BITS(SYM_BITS)) u_dec (
        .rail_i      (rail_i),
        .any_o       (any_w),
        .bit_true_o  (bt_w),
        .bit_false_o (bf_w),
        .clash_o     (clash_w)
    );

    always_comb begin
        st_d       = st_q;
        st_d.ack   = any_w;
        st_d.err   = clash_w;
        st_d.valid = any_w && !st_q.ack && !clash_w;
        if (st_d.valid) st_d.word = bt_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_o   = st_q.ack;
    assign valid_o = st_q.valid;
    assign err_o   = st_q.err;
    assign word_o  = st_q.word;

    // R6: completion raises the acknowledge on the next cycle
    a_r6_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (|rail_i) |=> ack_o);
    // R6: spacer drops the acknowledge on the next cycle
    a_r6_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_i == '0) |=> !ack_o);
    // R8: strobe lasts one clock and coincides with the acknowledge rising
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    a_r8_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ack_o);
    // R9 / R10: multi-hot flags an error and yields no word
    a_r9_multi_hot: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(rail_i) > 1) |=> (err_o && !valid_o));
endmodule

// File: rtl/qr_link.sv
module qr_link #(
    parameter int SYM_BITS = 2,
    localparam int RAILS = 1 << SYM_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SYM_BITS-1:0] in_word,
    input  logic                in_valid,
    output logic                in_ready,
    output logic [RAILS-1:0]    tx_rail,
    input  logic                tx_ack,
    input  logic [RAILS-1:0]    rx_rail,
    output logic                rx_ack,
    output logic [SYM_BITS-1:0] out_word,
    output logic                out_valid,
    output logic                rx_err
);
    qr_tx #(.SYM_BITS(SYM_BITS)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_i  (in_word),
        .valid_i (in_valid),
        .ready_o (in_ready),
        .rail_o  (tx_rail),
        .ack_i   (tx_ack)
    );

    qr_rx #(.SYM_BITS(SYM_BITS)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rail_i  (rx_rail),
        .ack_o   (rx_ack),
        .word_o  (out_word),
        .valid_o (out_valid),
        .err_o   (rx_err)
    );
endmodule

// File: tb/qr_link_test.sv
module qr_link_test;
    localparam int SB = 2;
    localparam int NR = 1 << SB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SB-1:0] in_word = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [NR-1:0] tx_rail, rx_rail;
    logic          rx_ack, out_valid, rx_err;
    logic [SB-1:0] out_word;
    logic          inj_en = 1'b0;
    logic [NR-1:0] inj_val = '0;
    logic          inj_mode = 1'b0;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    assign rx_rail = inj_en ? inj_val : tx_rail;

    qr_link #(.SYM_BITS(SB)) uut (
        .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
        .in_ready(in_ready), .tx_rail(tx_rail), .tx_ack(rx_ack),
        .rx_rail(rx_rail), .rx_ack(rx_ack), .out_word(out_word),
        .out_valid(out_valid), .rx_err(rx_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int            m_phase = 0;   // 0 idle, 1 holding codeword, 2 waiting ack low
    logic [NR-1:0] m_rail = '0;
    logic          m_ack = 1'b0, m_ov = 1'b0, m_err = 1'b0;
    logic [SB-1:0] m_word = '0;
    int            sent_q[$];
    logic [NR-1:0] prev_rail = '0;

    function automatic int ones(input logic [NR-1:0] v);
        int n = 0;
        for (int i = 0; i < NR; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic int first_set(input logic [NR-1:0] v);
        for (int i = 0; i < NR; i++) if (v[i]) return i;
        return 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase <= 0; m_rail <= '0; m_ack <= 1'b0; m_ov <= 1'b0; m_err <= 1'b0;
        end else begin
            logic [NR-1:0] link;
            link = inj_en ? inj_val : m_rail;
            case (m_phase)
                0: if (in_valid && !m_ack) begin
                       m_rail <= NR'(1) << in_word;
                       m_phase <= 1;
                       sent_q.push_back(int'(in_word));
                   end
                1: if (m_ack) begin m_rail <= '0; m_phase <= 2; end
                default: if (!m_ack) m_phase <= 0;
            endcase
            m_ack <= (link != '0);
            m_err <= ones(link) > 1;
            m_ov  <= (link != '0) && !m_ack && ones(link) == 1;
            if ((link != '0) && !m_ack && ones(link) == 1) m_word <= SB'(first_set(link));
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check(tx_rail == m_rail, "R2/R4 tx_rail", int'(tx_rail), int'(m_rail));
            check(in_ready == (m_phase == 0 && !m_ack), "R3 in_ready",
                  int'(in_ready), int'(m_phase == 0 && !m_ack));
            check(rx_ack == m_ack, "R6 rx_ack", int'(rx_ack), int'(m_ack));
            check(out_valid == m_ov, "R8 out_valid", int'(out_valid), int'(m_ov));
            check(rx_err == m_err, "R9 rx_err", int'(rx_err), int'(m_err));
            if (m_ov) check(out_word == m_word, "R7 out_word", int'(out_word), int'(m_word));
            if (prev_rail != '0 && tx_rail != '0)
                check(tx_rail == prev_rail, "R5 spacer between codewords",
                      int'(tx_rail), int'(prev_rail));
            if (out_valid && !inj_mode) begin
                int e;
                e = (sent_q.size() > 0) ? sent_q.pop_front() : -1;
                check(int'(out_word) == e, "R7 order", int'(out_word), e);
            end
            prev_rail = tx_rail;
        end
    end

    task automatic send(input int w);
        in_word  = SB'(w);
        in_valid = 1'b1;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic inject(input logic [NR-1:0] v, input bit expect_err, input int expect_word);
        @(negedge clk);
        inj_val = v;
        inj_en  = 1'b1;
        @(negedge clk);
        check(rx_ack == 1'b1, "R10 ack on any codeword", int'(rx_ack), 1);
        check(rx_err == expect_err, "R9 error flag", int'(rx_err), int'(expect_err));
        check(out_valid == !expect_err, "R10 strobe only for single-hot",
              int'(out_valid), int'(!expect_err));
        if (!expect_err) check(int'(out_word) == expect_word, "R7 injected decode",
                               int'(out_word), expect_word);
        inj_val = '0;
        repeat (3) @(negedge clk);
        check(rx_ack == 1'b0 && rx_err == 1'b0, "R6 release after spacer",
              int'({rx_ack, rx_err}), 0);
        inj_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(tx_rail == '0, "R1 tx_rail", int'(tx_rail), 0);
        check(rx_ack == 1'b0, "R1 rx_ack", int'(rx_ack), 0);
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(rx_err == 1'b0, "R1 rx_err", int'(rx_err), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: each value raises its own rail
        for (int v = 0; v < NR; v++) begin
            in_word = SB'(v);
            in_valid = 1'b1;
            #1;
            while (!in_ready) begin @(negedge clk); #1; end
            @(negedge clk);
            in_valid = 1'b0;
            check(tx_rail == (NR'(1) << v), "R2 code mapping", int'(tx_rail), 1 << v);
            repeat (6) @(negedge clk);
        end

        // R3/R5: back-to-back offers with valid held
        for (int i = 0; i < 24; i++) send(int'($urandom_range(0, NR - 1)));
        repeat (8) @(negedge clk);

        // R3: offer held during a busy handshake is taken only after it
        in_word = 2'd3; in_valid = 1'b1;
        #1; while (!in_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        in_word = 2'd1;
        @(negedge clk);
        check(in_ready == 1'b0, "R3 busy not ready", int'(in_ready), 0);
        check(tx_rail == 4'b1000, "R4 hold codeword", int'(tx_rail), 8);
        #1; while (!in_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (8) @(negedge clk);

        // R9/R10: illegal and legal codewords injected at the receiver
        inj_mode = 1'b1;
        inject(4'b0101, 1'b1, 0);
        inject(4'b1110, 1'b1, 0);
        inject(4'b1000, 1'b0, 3);
        inject(4'b0010, 1'b0, 1);
        inj_mode = 1'b0;
        repeat (4) @(negedge clk);
        check(sent_q.size() == 0, "R7 all words delivered", sent_q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule